// File: doc/BRIEF.md
# SMT-Partitioned Return Address Stack

This block predicts return targets for a core that runs two hardware threads. One storage array of return addresses is shared by both threads. Its split depends on which threads are active. When both threads are active, each thread has a private circular stack in its own half of the array. When exactly one thread is active, that thread uses the whole array as one circular stack of twice the size. A call pushes its return address onto the calling thread's stack. A return pops the top entry, and that entry becomes the prediction, together with a valid flag.

A mode switch leaves the stored addresses untouched. Only each thread's top pointer and occupancy count are recomputed. Because of this, a thread that has just become the only active one can pop an address that its sibling wrote. This cross-thread reuse is reproducible, and the block keeps it on purpose. A per-thread flush clears a thread's pointer and count but keeps the stored data. After a flush, a run of pushes as long as the thread's visible capacity overwrites every entry the thread can reach.

Top module: `smt_ras`

## Requirements
- R1: When both threads are active, thread t owns array entries t*HALF_DEPTH to t*HALF_DEPTH+HALF_DEPTH-1. Each thread's pushes and pops act as a private last-in-first-out stack, and no thread ever reads or writes the other half.
- R2: The mode comes from the activity inputs in the same cycle. active_i = 2'b11 selects the dual mode. 2'b01 selects single mode with thread 0. 2'b10 selects single mode with thread 1. 2'b00 halts all operations. Operations in a cycle follow that cycle's mode.
- R3: Stored addresses are never cleared or rewritten by a mode change. When a thread leaves single mode, its pointer becomes t*HALF_DEPTH + (pointer mod HALF_DEPTH) and its count is capped at HALF_DEPTH. The other thread keeps its pointer and count.
- R4: When thread t enters single mode, its count becomes min(own count + sibling count, 2*HALF_DEPTH) and its pointer is unchanged. It then pushes and pops over the whole array, wrapping mod 2*HALF_DEPTH. A pop made right after the switch can return an entry the sibling wrote.
- R5: A pop with a non-zero count drives pred_valid_o[t]=1 and the popped address on pred_addr_o[t] in the cycle after the request. In every other cycle, pred_valid_o[t]=0 and pred_addr_o[t]=0.
- R6: A push when the stack is full overwrites the oldest entry. The count saturates at HALF_DEPTH in dual mode and at 2*HALF_DEPTH in single mode.
- R7: A pop with a zero count gives valid 0 and leaves the pointer and count unchanged.
- R8: A push and a pop from the same thread in the same cycle are handled pop first. The pop returns the old top, and the pushed address takes its slot.
- R9: flush_i[t] sets thread t's pointer to t*HALF_DEPTH and its count to 0, and keeps stored data. A push or pop in the same cycle is dropped. A following run of pushes equal to the visible capacity overwrites every visible entry.
- R10: Push and pop requests from a thread whose active_i bit is 0 are ignored.
- R11: After reset, every entry is 0, every count is 0, thread t's pointer is t*HALF_DEPTH, the mode history is dual, and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| active_i | input | 2 | Per-thread active status, 1 = running |
| push_i | input | 2 | Per-thread call push request |
| push_addr_i | input | 2 x ADDR_W | Per-thread return address to push |
| pop_i | input | 2 | Per-thread return pop request |
| flush_i | input | 2 | Per-thread pointer and count reset |
| pred_valid_o | output | 2 | Per-thread prediction valid, one cycle after pop |
| pred_addr_o | output | 2 x ADDR_W | Per-thread predicted return address |

## Verification
The bench builds the block with HALF_DEPTH=4 and ADDR_W=16. Each half then fills after four pushes, and the merged stack fills after eight. This makes overflow wrap in both modes and the merged-count handoff reachable in a few cycles. The small array also means that a single-mode pop soon crosses into the sibling's half. So the cross-thread reuse after a switch, the capping on the way back, and the flush-then-fill sequence can each be checked directly against known addresses. A random phase also mixes mode changes with concurrent pushes, pops and flushes.

// File: rtl/smt_ras_pkg.sv
package smt_ras_pkg;

   localparam int NUM_THR = 2;

   typedef enum logic [1:0] {
      MODE_DUAL  = 2'd0,
      MODE_SOLO0 = 2'd1,
      MODE_SOLO1 = 2'd2,
      MODE_HALT  = 2'd3
   } ras_mode_e;

endpackage

// File: rtl/ras_mode_ctrl.sv
module ras_mode_ctrl
   import smt_ras_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_THR-1:0] active_i,
   output ras_mode_e          mode_now_o,
   output ras_mode_e          mode_prev_o
);

   ras_mode_e mode_q;

   always_comb begin
      unique case (active_i)
         2'b11:   mode_now_o = MODE_DUAL;
         2'b01:   mode_now_o = MODE_SOLO0;
         2'b10:   mode_now_o = MODE_SOLO1;
         default: mode_now_o = MODE_HALT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MODE_DUAL;
      else        mode_q <= mode_now_o;
   end

   assign mode_prev_o = mode_q;

   AST_HALT_NO_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_now_o == MODE_HALT) |-> (active_i == '0)); // R2

endmodule

// File: rtl/ras_thread_ctl.sv
module ras_thread_ctl
   import smt_ras_pkg::*;
#(
   parameter  int THREAD     = 0,
   parameter  int HALF_DEPTH = 16,
   localparam int DEPTH      = 2 * HALF_DEPTH,
   localparam int IDX_W      = $clog2(DEPTH),
   localparam int CNT_W      = IDX_W + 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  ras_mode_e        mode_now_i,
   input  ras_mode_e        mode_prev_i,
   input  logic             active_i,
   input  logic             push_i,
   input  logic             pop_i,
   input  logic             flush_i,
   input  logic [CNT_W-1:0] peer_cnt_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             we_o,
   output logic [IDX_W-1:0] widx_o,
   output logic             re_o,
   output logic [IDX_W-1:0] ridx_o,
   output logic             pred_valid_o
);

   localparam ras_mode_e        MY_SOLO = (THREAD == 0) ? MODE_SOLO0 : MODE_SOLO1;
   localparam logic [IDX_W-1:0] BASE    = IDX_W'(THREAD * HALF_DEPTH);
   localparam logic [CNT_W-1:0] HALF_C  = CNT_W'(HALF_DEPTH);
   localparam logic [CNT_W-1:0] FULL_C  = CNT_W'(DEPTH);

   logic [IDX_W-1:0] ptr_q, ptr_a, ptr_b, ptr_n;
   logic [CNT_W-1:0] cnt_q, cnt_a, cnt_b, cnt_n, cap;
   logic [CNT_W:0]   merged;
   logic             solo_now, solo_prev, pop_go, push_go, pop_hit;
   logic             pred_valid_q;

   function automatic logic [IDX_W-1:0] ring_step(input logic [IDX_W-1:0] idx,
                                                  input logic up,
                                                  input logic whole);
      logic [IDX_W-1:0] nxt;
      nxt = up ? idx + 1'b1 : idx - 1'b1;
      if (!whole) nxt[IDX_W-1] = idx[IDX_W-1];
      return nxt;
   endfunction

   assign solo_now  = (mode_now_i == MY_SOLO);
   assign solo_prev = (mode_prev_i == MY_SOLO);
   assign cap       = solo_now ? FULL_C : HALF_C;

   // pointer and count repartition on a mode change
   always_comb begin
      ptr_a  = ptr_q;
      cnt_a  = cnt_q;
      merged = '0;
      if (solo_prev && !solo_now) begin
         ptr_a = {BASE[IDX_W-1], ptr_q[IDX_W-2:0]};
         if (cnt_q > HALF_C) cnt_a = HALF_C;
      end
      if (solo_now && !solo_prev) begin
         merged = {1'b0, cnt_a} + {1'b0, peer_cnt_i};
         cnt_a  = (merged > {1'b0, FULL_C}) ? FULL_C : merged[CNT_W-1:0];
      end
   end

   // pop first, then push
   assign pop_go  = active_i && pop_i && !flush_i;
   assign push_go = active_i && push_i && !flush_i;
   assign pop_hit = pop_go && (cnt_a != '0);
   assign ridx_o  = ring_step(ptr_a, 1'b0, solo_now);
   assign re_o    = pop_hit;

   always_comb begin
      ptr_b = pop_hit ? ridx_o : ptr_a;
      cnt_b = pop_hit ? cnt_a - 1'b1 : cnt_a;
      ptr_n = ptr_b;
      cnt_n = cnt_b;
      if (push_go) begin
         ptr_n = ring_step(ptr_b, 1'b1, solo_now);
         cnt_n = (cnt_b >= cap) ? cap : cnt_b + 1'b1;
      end
      if (flush_i) begin
         ptr_n = BASE;
         cnt_n = '0;
      end
   end

   assign we_o   = push_go;
   assign widx_o = ptr_b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q        <= BASE;
         cnt_q        <= '0;
         pred_valid_q <= 1'b0;
      end else begin
         ptr_q        <= ptr_n;
         cnt_q        <= cnt_n;
         pred_valid_q <= pop_hit;
      end
   end

   assign cnt_o        = cnt_q;
   assign pred_valid_o = pred_valid_q;

   AST_DUAL_OWN_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_now_i == MODE_DUAL) |=> (ptr_q[IDX_W-1] == BASE[IDX_W-1])); // R1
   AST_DUAL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_now_i == MODE_DUAL) |=> (cnt_q <= HALF_C)); // R6
   AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (active_i && pop_i && !push_i && (cnt_a == '0)) |=> (!pred_valid_q && cnt_q == '0)); // R7
   AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (cnt_q == '0 && ptr_q == BASE && !pred_valid_q)); // R9
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_i && !flush_i && mode_now_i == mode_prev_i) |=> ($stable(ptr_q) && !pred_valid_q)); // R10

endmodule

// File: rtl/ras_store.sv
module ras_store
   import smt_ras_pkg::*;
#(
   parameter  int DEPTH  = 32,
   parameter  int ADDR_W = 32,
   localparam int IDX_W  = $clog2(DEPTH)
)(
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_THR-1:0]              we_i,
   input  logic [NUM_THR-1:0][IDX_W-1:0]   widx_i,
   input  logic [NUM_THR-1:0][ADDR_W-1:0]  wdata_i,
   input  logic [NUM_THR-1:0]              re_i,
   input  logic [NUM_THR-1:0][IDX_W-1:0]   ridx_i,
   output logic [NUM_THR-1:0][ADDR_W-1:0]  rdata_o
);

   logic [ADDR_W-1:0]                 mem_q [DEPTH];
   logic [NUM_THR-1:0][ADDR_W-1:0]    rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < DEPTH; e++) mem_q[e] <= '0;
      end else begin
         for (int p = NUM_THR - 1; p >= 0; p--) begin
            if (we_i[p]) mem_q[widx_i[p]] <= wdata_i[p];
         end
      end
   end

   // reads see the array before this cycle's writes (pop before push)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= '0;
      end else begin
         for (int p = 0; p < NUM_THR; p++) begin
            rd_q[p] <= re_i[p] ? mem_q[ridx_i[p]] : '0;
         end
      end
   end

   assign rdata_o = rd_q;

   AST_WR_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i[0] && we_i[1]) |-> (widx_i[0][IDX_W-1] != widx_i[1][IDX_W-1])); // R1

endmodule

// File: rtl/smt_ras.sv
module smt_ras
   import smt_ras_pkg::*;
#(
   parameter int HALF_DEPTH = 16,
   parameter int ADDR_W     = 32
)(
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_THR-1:0]             active_i,
   input  logic [NUM_THR-1:0]             push_i,
   input  logic [NUM_THR-1:0][ADDR_W-1:0] push_addr_i,
   input  logic [NUM_THR-1:0]             pop_i,
   input  logic [NUM_THR-1:0]             flush_i,
   output logic [NUM_THR-1:0]             pred_valid_o,
   output logic [NUM_THR-1:0][ADDR_W-1:0] pred_addr_o
);

   localparam int DEPTH = 2 * HALF_DEPTH;
   localparam int IDX_W = $clog2(DEPTH);
   localparam int CNT_W = IDX_W + 1;

   if (HALF_DEPTH < 2 || (HALF_DEPTH & (HALF_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("smt_ras: HALF_DEPTH must be a power of two of at least 2");
   end
   if (ADDR_W < 1) begin : g_bad_width
      $error("smt_ras: ADDR_W must be positive");
   end

   ras_mode_e                    mode_now, mode_prev;
   logic [CNT_W-1:0]             cnt [NUM_THR];
   logic [NUM_THR-1:0]           we, re;
   logic [NUM_THR-1:0][IDX_W-1:0] widx, ridx;

   ras_mode_ctrl u_mode (
      .clk         (clk),
      .rst_n       (rst_n),
      .active_i    (active_i),
      .mode_now_o  (mode_now),
      .mode_prev_o (mode_prev)
   );

   for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
      ras_thread_ctl #(
         .THREAD     (t),
         .HALF_DEPTH (HALF_DEPTH)
      ) u_ctl (
         .clk          (clk),
         .rst_n        (rst_n),
         .mode_now_i   (mode_now),
         .mode_prev_i  (mode_prev),
         .active_i     (active_i[t]),
         .push_i       (push_i[t]),
         .pop_i        (pop_i[t]),
         .flush_i      (flush_i[t]),
         .peer_cnt_i   (cnt[NUM_THR-1-t]),
         .cnt_o        (cnt[t]),
         .we_o         (we[t]),
         .widx_o       (widx[t]),
         .re_o         (re[t]),
         .ridx_o       (ridx[t]),
         .pred_valid_o (pred_valid_o[t])
      );
   end

   ras_store #(
      .DEPTH  (DEPTH),
      .ADDR_W (ADDR_W)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (we),
      .widx_i  (widx),
      .wdata_i (push_addr_i),
      .re_i    (re),
      .ridx_i  (ridx),
      .rdata_o (pred_addr_o)
   );

   AST_SOLO_SINGLE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_now != MODE_DUAL) |-> $onehot0(we)); // R4

endmodule

// File: tb/smt_ras_bench.sv
module smt_ras_bench;

   localparam int H  = 4;
   localparam int D  = 2 * H;
   localparam int AW = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0]        active_i = '0, push_i = '0, pop_i = '0, flush_i = '0;
   logic [1:0][AW-1:0] push_addr_i = '0;
   logic [1:0]        pred_valid_o;
   logic [1:0][AW-1:0] pred_addr_o;

   int nchk = 0, nerr = 0;
   bit done = 0;

   // reference model state
   int m_mem [D];
   int m_ptr [2];
   int m_cnt [2];
   int m_prev;
   int ev [2];
   int ea [2];

   always #2 clk = ~clk;

   smt_ras #(.HALF_DEPTH(H), .ADDR_W(AW)) u_smt_ras (
      .clk(clk), .rst_n(rst_n), .active_i(active_i), .push_i(push_i),
      .push_addr_i(push_addr_i), .pop_i(pop_i), .flush_i(flush_i),
      .pred_valid_o(pred_valid_o), .pred_addr_o(pred_addr_o)
   );

   function automatic int mode_of(logic [1:0] a);
      case (a)
         2'b11:   return 0;
         2'b01:   return 1;
         2'b10:   return 2;
         default: return 3;
      endcase
   endfunction

   task automatic model_reset();
      for (int i = 0; i < D; i++) m_mem[i] = 0;
      for (int t = 0; t < 2; t++) begin
         m_ptr[t] = t * H; m_cnt[t] = 0; ev[t] = 0; ea[t] = 0;
      end
      m_prev = 0;
   endtask

   task automatic model_step(logic [1:0] act, logic [1:0] psh, logic [1:0] pp,
                             logic [1:0] fl, int d0, int d1);
      int mn, oc[2], wi[2], wv[2], wen[2], base, size;
      bit sn, sp;
      mn = mode_of(act);
      oc[0] = m_cnt[0]; oc[1] = m_cnt[1];
      for (int t = 0; t < 2; t++) begin
         sn = (mn == t + 1); sp = (m_prev == t + 1);
         if (sp && !sn) begin
            m_ptr[t] = t * H + (m_ptr[t] % H);
            if (m_cnt[t] > H) m_cnt[t] = H;
         end
         if (sn && !sp) begin
            m_cnt[t] = m_cnt[t] + oc[1 - t];
            if (m_cnt[t] > D) m_cnt[t] = D;
         end
      end
      for (int t = 0; t < 2; t++) begin
         sn = (mn == t + 1);
         base = sn ? 0 : t * H;
         size = sn ? D : H;
         ev[t] = 0; ea[t] = 0; wen[t] = 0; wi[t] = 0;
         wv[t] = (t == 0) ? d0 : d1;
         if (fl[t]) begin
            m_ptr[t] = t * H; m_cnt[t] = 0;
         end else if (act[t]) begin
            if (pp[t] && m_cnt[t] > 0) begin
               m_ptr[t] = base + ((m_ptr[t] - base - 1 + size) % size);
               ev[t] = 1; ea[t] = m_mem[m_ptr[t]];
               m_cnt[t]--;
            end
            if (psh[t]) begin
               wen[t] = 1; wi[t] = m_ptr[t];
               m_ptr[t] = base + ((m_ptr[t] - base + 1) % size);
               if (m_cnt[t] < size) m_cnt[t]++;
            end
         end
      end
      for (int t = 0; t < 2; t++) if (wen[t]) m_mem[wi[t]] = wv[t];
      m_prev = mn;
   endtask

   task automatic chk(string tag, string what, int got, int exp);
      nchk++;
      if (got != exp) begin
         nerr++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, got, exp);
      end
   endtask

   task automatic cyc(logic [1:0] act, logic [1:0] psh, logic [1:0] pp, logic [1:0] fl,
                      int d0, int d1, string tag);
      @(negedge clk);
      active_i = act; push_i = psh; pop_i = pp; flush_i = fl;
      push_addr_i[0] = AW'(d0); push_addr_i[1] = AW'(d1);
      model_step(act, psh, pp, fl, d0, d1);
      @(posedge clk); #1;
      for (int t = 0; t < 2; t++) begin
         chk(tag, $sformatf("t%0d valid", t), int'(pred_valid_o[t]), ev[t]);
         chk(tag, $sformatf("t%0d addr", t), int'(pred_addr_o[t]), ea[t]);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         nerr++; nchk++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin : main
      model_reset();
      repeat (3) @(posedge clk);
      #1;
      chk("R11", "valid after reset", int'(pred_valid_o), 0);
      chk("R11", "addr after reset", int'(pred_addr_o), 0);
      @(negedge clk); rst_n = 1'b1;

      // R11: empty pops straight after reset
      cyc(2'b11, 2'b00, 2'b11, 2'b00, 0, 0, "R11");

      // R1: private stacks in dual mode
      cyc(2'b11, 2'b11, 2'b00, 2'b00, 'h1001, 'h2001, "R1");
      cyc(2'b11, 2'b01, 2'b00, 2'b00, 'h1002, 0, "R1");
      cyc(2'b11, 2'b00, 2'b11, 2'b00, 0, 0, "R1");
      chk("R1", "t0 lifo top", int'(pred_addr_o[0]), 'h1002);
      chk("R5", "t1 own entry", int'(pred_addr_o[1]), 'h2001);
      cyc(2'b11, 2'b00, 2'b11, 2'b00, 0, 0, "R1");
      cyc(2'b11, 2'b00, 2'b00, 2'b00, 0, 0, "R5");

      // R6 overflow wrap and R7 underflow in dual mode
      for (int i = 0; i < 6; i++) cyc(2'b11, 2'b01, 2'b00, 2'b00, 'h3000 + i, 0, "R6");
      for (int i = 0; i < 5; i++) cyc(2'b11, 2'b00, 2'b01, 2'b00, 0, 0, "R6");
      chk("R7", "underflow pop invalid", int'(pred_valid_o[0]), 0);
      cyc(2'b11, 2'b00, 2'b01, 2'b00, 0, 0, "R7");

      // R8: same-cycle pop then push
      cyc(2'b11, 2'b01, 2'b00, 2'b00, 'h4001, 0, "R8");
      cyc(2'b11, 2'b01, 2'b01, 2'b00, 'h4002, 0, "R8");
      chk("R8", "pop returns old top", int'(pred_addr_o[0]), 'h4001);
      cyc(2'b11, 2'b00, 2'b01, 2'b00, 0, 0, "R8");
      chk("R8", "push replaced slot", int'(pred_addr_o[0]), 'h4002);

      // R10: idle thread requests ignored
      cyc(2'b11, 2'b10, 2'b00, 2'b00, 0, 'h5001, "R10");
      cyc(2'b01, 2'b10, 2'b10, 2'b00, 0, 'h5BAD, "R10");
      chk("R10", "idle pop gives nothing", int'(pred_valid_o[1]), 0);
      cyc(2'b11, 2'b00, 2'b10, 2'b00, 0, 0, "R10");
      chk("R10", "idle push dropped", int'(pred_addr_o[1]), 'h5001);

      // R9: flush then safe fill over the visible half
      cyc(2'b11, 2'b01, 2'b00, 2'b00, 'h6001, 0, "R9");
      cyc(2'b11, 2'b01, 2'b00, 2'b01, 'h6BAD, 0, "R9");
      cyc(2'b11, 2'b00, 2'b01, 2'b00, 0, 0, "R9");
      chk("R9", "pop after flush invalid", int'(pred_valid_o[0]), 0);
      for (int i = 0; i < H; i++) cyc(2'b11, 2'b01, 2'b00, 2'b00, 'h7000 + i, 0, "R9");
      for (int i = 0; i < H + 1; i++) cyc(2'b11, 2'b00, 2'b01, 2'b00, 0, 0, "R9");

      // R4: cross-thread reuse right after entering single mode
      cyc(2'b11, 2'b00, 2'b00, 2'b11, 0, 0, "R4");
      for (int i = 0; i < H; i++) cyc(2'b11, 2'b01, 2'b00, 2'b00, 'hA000 + i, 0, "R4");
      cyc(2'b10, 2'b00, 2'b10, 2'b00, 0, 0, "R4");
      chk("R4", "leaked sibling entry valid", int'(pred_valid_o[1]), 1);
      chk("R4", "leaked sibling entry", int'(pred_addr_o[1]), 'hA000 + H - 1);
      for (int i = 0; i < 3; i++) cyc(2'b10, 2'b10, 2'b00, 2'b00, 0, 'hB000 + i, "R4");

      // R3: back to dual mode, thread 0 entries retained
      cyc(2'b11, 2'b00, 2'b11, 2'b00, 0, 0, "R3");
      for (int i = 0; i < 4; i++) cyc(2'b11, 2'b00, 2'b11, 2'b00, 0, 0, "R3");

      // R6/R9: full-array fill in single mode
      cyc(2'b01, 2'b00, 2'b00, 2'b01, 0, 0, "R9");
      for (int i = 0; i < D + 2; i++) cyc(2'b01, 2'b01, 2'b00, 2'b00, 'hC000 + i, 0, "R6");
      for (int i = 0; i < D + 1; i++) cyc(2'b01, 2'b00, 2'b01, 2'b00, 0, 0, "R6");
      chk("R7", "solo underflow invalid", int'(pred_valid_o[0]), 0);

      // R2: mixed traffic with mode changes, compared every cycle
      for (int i = 0; i < 600; i++) begin
         logic [1:0] a, ps, pp, fl;
         int r;
         r  = int'($urandom_range(0, 9));
         a  = (r < 6) ? 2'b11 : 2'(r % 4);
         ps = 2'($urandom_range(0, 3));
         pp = 2'($urandom_range(0, 3));
         fl = ($urandom_range(0, 30) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
         cyc(a, ps, pp, fl, int'($urandom_range(0, 'hFFFF)), int'($urandom_range(0, 'hFFFF)), "R2");
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule